// File: doc/BRIEF.md
# Transmit Checksum Insertion Engine

This block takes one outgoing frame as a byte stream and stores it in a local frame buffer. With the first byte it captures a set of per-frame control fields. The fields describe up to two Internet checksums. Each checksum has its own enable, a byte range and a write position. Context A is the outer checksum, for example over a network header. Context B is the inner checksum, for example a transport checksum.

Once the final byte is stored, the engine works on the buffer. It sums context B's range, writes B's result, then sums context A's range and writes A's result. Because B is written first, A's range may cover B's field and will see the value just inserted. The modified frame is then sent out on an output byte stream. Pseudo-header material is not built here: software places any seed value in the checksum field before handing the frame over, and that value takes part in the sum.

Top module: `csum_insert`

## Requirements
- R1: A byte is taken on a clock edge where `in_valid` and `in_ready` are both high, and `in_last` marks the final byte of the frame. `in_ready` is low from the edge after the final byte is taken until the output stream has finished. The output stream carries every stored byte in order, one per cycle with `out_valid` high, and `out_last` is high on the final byte only.
- R2: The control inputs are sampled only together with the first byte of a frame. Changing them later in the same frame has no effect.
- R3: The inserted value is the bitwise complement of the 16-bit one's-complement sum, with end-around carry, of the range. The range is read as 16-bit words whose first byte is the high byte, counting from the range start.
- R4: A range with an odd byte count is summed as if its final byte were followed by a zero low byte.
- R5: A result is written with its high byte at the insert offset and its low byte at the insert offset plus one. Whatever those two bytes held before takes part in any sum whose range covers them.
- R6: Context B is summed and inserted before context A is summed. A's sum therefore uses B's inserted bytes when A's range covers them.
- R7: Each context has its own enable bit. A disabled context changes no byte. With both contexts off, the frame leaves unchanged.
- R8: The start offset is inclusive and the end offset is exclusive. An end of 0, or an end beyond the frame length, means the range runs to the frame end. A start at or past the end gives an empty range, whose result is 0xFFFF.
- R9: When `ctl_udp` is set, a context B result of 0x0000 is written as 0xFFFF. Context A results, and B results with the flag clear, are written as computed.
- R10: After reset, `out_valid` and `out_last` are low and `in_ready` is high.
- R11: The buffer holds MAX_FRAME bytes. Bytes beyond that in one frame are dropped, and the frame goes out with exactly MAX_FRAME bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Engine accepts input bytes |
| in_data | input | 8 | Input frame byte |
| in_last | input | 1 | Final byte of the frame |
| ctl_a_en | input | 1 | Enable outer checksum |
| ctl_a_start | input | AW | Outer range first byte |
| ctl_a_end | input | AW | Outer range end, exclusive, 0 = frame end |
| ctl_a_ins | input | AW | Outer result offset |
| ctl_b_en | input | 1 | Enable inner checksum |
| ctl_b_start | input | AW | Inner range first byte |
| ctl_b_end | input | AW | Inner range end, exclusive, 0 = frame end |
| ctl_b_ins | input | AW | Inner result offset |
| ctl_udp | input | 1 | Send a zero inner result as 0xFFFF |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output frame byte |
| out_last | output | 1 | Final output byte |

## Verification
The hardest case to reach is a context B sum that comes to exactly 0xFFFF, since only that case yields a 0x0000 result and exercises the UDP substitution. The stimulus fills whole frames with 0xFF bytes, which forces that sum for any even-length range. Three runs then cover the same frame with the flag set, with it clear, and with the range moved to context A. Nested ranges are covered by placing B's field inside A's range, so that a wrong processing order changes A's result.

// File: rtl/csum_pkg.sv
package csum_pkg;

  localparam int CSUM_W = 16;

  typedef enum logic [2:0] {
    ST_LOAD,
    ST_SETUP,
    ST_SUM,
    ST_INS_HI,
    ST_INS_LO,
    ST_SEND
  } csum_state_e;

endpackage

// File: rtl/csum_frame_buf.sv
module csum_frame_buf #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/csum_accum.sv
module csum_accum (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       add,
  input  logic                       hi_sel,
  input  logic [7:0]                 byte_in,
  output logic [csum_pkg::CSUM_W-1:0] acc
);
  import csum_pkg::*;

  logic [CSUM_W-1:0] acc_q;
  logic [CSUM_W-1:0] acc_d;
  logic [CSUM_W-1:0] word;
  logic [CSUM_W:0]   wide;

  always_comb begin
    word  = hi_sel ? {byte_in, 8'h00} : {8'h00, byte_in};
    wide  = {1'b0, acc_q} + {1'b0, word};
    acc_d = acc_q;
    if (clr) begin
      acc_d = '0;
    end else if (add) begin
      acc_d = wide[CSUM_W-1:0] + {{(CSUM_W-1){1'b0}}, wide[CSUM_W]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else begin
      acc_q <= acc_d;
    end
  end

  assign acc = acc_q;

  // R3
  eac_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (add && !clr && byte_in != 8'h00) |=> (acc != '0));

  // R3
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc == '0));

endmodule

// File: rtl/csum_insert.sv
module csum_insert #(
  parameter int MAX_FRAME = 64,
  localparam int AW = $clog2(MAX_FRAME)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [7:0]    in_data,
  input  logic          in_last,
  input  logic          ctl_a_en,
  input  logic [AW-1:0] ctl_a_start,
  input  logic [AW-1:0] ctl_a_end,
  input  logic [AW-1:0] ctl_a_ins,
  input  logic          ctl_b_en,
  input  logic [AW-1:0] ctl_b_start,
  input  logic [AW-1:0] ctl_b_end,
  input  logic [AW-1:0] ctl_b_ins,
  input  logic          ctl_udp,
  output logic          out_valid,
  output logic [7:0]    out_data,
  output logic          out_last
);
  import csum_pkg::*;

  localparam int LEN_W = AW + 1;
  localparam logic [LEN_W-1:0] CAP = LEN_W'(MAX_FRAME);

  typedef struct packed {
    logic          en;
    logic [AW-1:0] beg;
    logic [AW-1:0] fin;
    logic [AW-1:0] ins;
  } ctx_t;

  // reset: asynchronous assert, synchronous release
  logic rst_meta, rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_i    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_i    <= rst_meta;
    end
  end

  csum_state_e       state_q, state_d;
  logic [LEN_W-1:0]  cnt_q, cnt_d;
  logic [LEN_W-1:0]  len_q, len_d;
  logic [LEN_W-1:0]  ptr_q, ptr_d;
  logic [LEN_W-1:0]  lim_q, lim_d;
  logic              cur_q, cur_d;
  logic              hi_q, hi_d;
  logic              udp_q, udp_d;
  ctx_t              ctx_q [2];
  ctx_t              ctx_d [2];
  ctx_t              ctx_in [2];
  ctx_t              cur_ctx;
  logic              ov_q, ov_d;
  logic [7:0]        od_q, od_d;
  logic              ol_q, ol_d;

  logic              acc_clr, acc_add;
  logic [CSUM_W-1:0] acc;
  logic [CSUM_W-1:0] res_word;
  logic              buf_we;
  logic [AW-1:0]     buf_waddr, buf_raddr;
  logic [7:0]        buf_wdata, buf_rdata;
  logic              cnt_full;
  logic [LEN_W-1:0]  fin_ext;

  assign ctx_in[0] = '{en: ctl_a_en, beg: ctl_a_start, fin: ctl_a_end, ins: ctl_a_ins};
  assign ctx_in[1] = '{en: ctl_b_en, beg: ctl_b_start, fin: ctl_b_end, ins: ctl_b_ins};
  assign cur_ctx   = ctx_q[cur_q];
  assign cnt_full  = (cnt_q == CAP);
  assign fin_ext   = LEN_W'(cur_ctx.fin);
  assign in_ready  = rst_i && (state_q == ST_LOAD) && !ov_q;

  always_comb begin
    res_word = ~acc;
    if (cur_q && udp_q && (res_word == '0)) begin
      res_word = '1;
    end
  end

  csum_frame_buf #(.DEPTH(MAX_FRAME)) u_buf (
    .clk   (clk),
    .we    (buf_we),
    .waddr (buf_waddr),
    .wdata (buf_wdata),
    .raddr (buf_raddr),
    .rdata (buf_rdata)
  );

  csum_accum u_acc (
    .clk     (clk),
    .rst_n   (rst_i),
    .clr     (acc_clr),
    .add     (acc_add),
    .hi_sel  (hi_q),
    .byte_in (buf_rdata),
    .acc     (acc)
  );

  // next-state logic
  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    len_d     = len_q;
    ptr_d     = ptr_q;
    lim_d     = lim_q;
    cur_d     = cur_q;
    hi_d      = hi_q;
    udp_d     = udp_q;
    ctx_d     = ctx_q;
    ov_d      = 1'b0;
    od_d      = od_q;
    ol_d      = 1'b0;
    acc_clr   = 1'b0;
    acc_add   = 1'b0;
    buf_we    = 1'b0;
    buf_waddr = cnt_q[AW-1:0];
    buf_wdata = in_data;
    buf_raddr = ptr_q[AW-1:0];
    unique case (state_q)
      ST_LOAD: begin
        if (in_valid && in_ready) begin
          if (cnt_q == '0) begin
            ctx_d = ctx_in;
            udp_d = ctl_udp;
          end
          if (!cnt_full) begin
            buf_we = 1'b1;
            cnt_d  = cnt_q + 1'b1;
          end
          if (in_last) begin
            len_d = cnt_full ? cnt_q : cnt_q + 1'b1;
            cnt_d = '0;
            if (ctx_d[1].en) begin
              cur_d   = 1'b1;
              state_d = ST_SETUP;
            end else if (ctx_d[0].en) begin
              cur_d   = 1'b0;
              state_d = ST_SETUP;
            end else begin
              ptr_d   = '0;
              state_d = ST_SEND;
            end
          end
        end
      end
      ST_SETUP: begin
        ptr_d   = LEN_W'(cur_ctx.beg);
        lim_d   = (cur_ctx.fin == '0 || fin_ext > len_q) ? len_q : fin_ext;
        acc_clr = 1'b1;
        hi_d    = 1'b1;
        state_d = ST_SUM;
      end
      ST_SUM: begin
        if (ptr_q < lim_q) begin
          acc_add = 1'b1;
          hi_d    = ~hi_q;
          ptr_d   = ptr_q + 1'b1;
        end else begin
          state_d = ST_INS_HI;
        end
      end
      ST_INS_HI: begin
        buf_we    = 1'b1;
        buf_waddr = cur_ctx.ins;
        buf_wdata = res_word[15:8];
        state_d   = ST_INS_LO;
      end
      ST_INS_LO: begin
        buf_we    = 1'b1;
        buf_waddr = cur_ctx.ins + 1'b1;
        buf_wdata = res_word[7:0];
        if (cur_q && ctx_q[0].en) begin
          cur_d   = 1'b0;
          state_d = ST_SETUP;
        end else begin
          ptr_d   = '0;
          state_d = ST_SEND;
        end
      end
      ST_SEND: begin
        ov_d  = 1'b1;
        od_d  = buf_rdata;
        ol_d  = (ptr_q == len_q - 1'b1);
        ptr_d = ptr_q + 1'b1;
        if (ol_d) begin
          state_d = ST_LOAD;
        end
      end
      default: state_d = ST_LOAD;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      state_q <= ST_LOAD;
      cnt_q   <= '0;
      len_q   <= '0;
      ptr_q   <= '0;
      lim_q   <= '0;
      cur_q   <= 1'b0;
      hi_q    <= 1'b1;
      udp_q   <= 1'b0;
      ctx_q   <= '{default: '0};
      ov_q    <= 1'b0;
      od_q    <= '0;
      ol_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      len_q   <= len_d;
      ptr_q   <= ptr_d;
      lim_q   <= lim_d;
      cur_q   <= cur_d;
      hi_q    <= hi_d;
      udp_q   <= udp_d;
      ctx_q   <= ctx_d;
      ov_q    <= ov_d;
      od_q    <= od_d;
      ol_q    <= ol_d;
    end
  end

  assign out_valid = ov_q;
  assign out_data  = od_q;
  assign out_last  = ol_q;

  // R1
  last_valid_chk: assert property (@(posedge clk) disable iff (!rst_i)
    out_last |-> out_valid);

  // R1
  send_stream_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (state_q == ST_SEND) |=> out_valid);

  // R1
  ready_quiet_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (in_valid && in_ready && in_last) |=> !in_ready);

  // R9
  udp_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (state_q == ST_INS_HI && cur_q && udp_q) |-> (res_word != '0));

  // R11
  cnt_cap_chk: assert property (@(posedge clk) disable iff (!rst_i)
    cnt_q <= CAP);

  // R6
  order_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (state_q == ST_INS_LO && !cur_q) |=> (state_q == ST_SEND));

endmodule

// File: tb/csum_insert_test.sv
`timescale 1ns/1ps
module csum_insert_test;

  localparam int MAXF = 64;
  localparam int AW   = 6;

  typedef struct packed {
    logic [6:0]    len;
    logic [7:0]    seed;
    logic          a_en;
    logic [AW-1:0] a_s, a_e, a_i;
    logic          b_en;
    logic [AW-1:0] b_s, b_e, b_i;
    logic          udp;
  } vec_t;

  // len seed | A en,start,end,ins | B en,start,end,ins | udp
  localparam vec_t VT [10] = '{
    '{7'd20, 8'd3,  1'b1, 6'd0, 6'd10, 6'd4,  1'b0, 6'd0,  6'd0,  6'd0,  1'b0},
    '{7'd21, 8'd5,  1'b0, 6'd0, 6'd0,  6'd0,  1'b1, 6'd4,  6'd0,  6'd8,  1'b0},
    '{7'd40, 8'd7,  1'b1, 6'd0, 6'd20, 6'd10, 1'b1, 6'd14, 6'd0,  6'd30, 1'b0},
    '{7'd40, 8'd9,  1'b1, 6'd0, 6'd0,  6'd6,  1'b1, 6'd8,  6'd31, 6'd20, 1'b0},
    '{7'd16, 8'd0,  1'b0, 6'd0, 6'd0,  6'd0,  1'b1, 6'd0,  6'd0,  6'd2,  1'b1},
    '{7'd16, 8'd0,  1'b0, 6'd0, 6'd0,  6'd0,  1'b1, 6'd0,  6'd0,  6'd2,  1'b0},
    '{7'd16, 8'd0,  1'b1, 6'd0, 6'd0,  6'd2,  1'b0, 6'd0,  6'd0,  6'd0,  1'b1},
    '{7'd30, 8'd11, 1'b1, 6'd0, 6'd50, 6'd0,  1'b1, 6'd12, 6'd12, 6'd28, 1'b0},
    '{7'd12, 8'd13, 1'b0, 6'd0, 6'd0,  6'd0,  1'b0, 6'd0,  6'd0,  6'd0,  1'b0},
    '{7'd64, 8'd17, 1'b1, 6'd1, 6'd63, 6'd60, 1'b1, 6'd3,  6'd0,  6'd40, 1'b1}
  };

  logic clk, rst_n;
  logic in_valid, in_ready, in_last;
  logic [7:0] in_data;
  logic a_en, b_en, udp;
  logic [AW-1:0] a_s, a_e, a_i, b_s, b_e, b_i;
  logic out_valid, out_last;
  logic [7:0] out_data;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  logic [7:0] em  [0:127];
  logic [7:0] got [0:127];
  int ngot;

  csum_insert #(.MAX_FRAME(MAXF)) uut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .ctl_a_en(a_en), .ctl_a_start(a_s), .ctl_a_end(a_e), .ctl_a_ins(a_i),
    .ctl_b_en(b_en), .ctl_b_start(b_s), .ctl_b_end(b_e), .ctl_b_ins(b_i),
    .ctl_udp(udp),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      total = total + 1;
      bad   = bad + 1;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected < 150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    total = total + 1;
    if (act != exp) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] gen(input int i, input logic [7:0] seed);
    if (seed == 8'd0) return 8'hFF;
    return 8'((i * seed + 90) ^ (i << 3));
  endfunction

  task automatic model_ctx(input int sa, input int ea, input int ia,
                           input bit is_b, input bit u, input int len);
    int lim;
    int unsigned s;
    logic [15:0] r;
    lim = (ea == 0 || ea > len) ? len : ea;
    s = 0;
    for (int k = sa; k < lim; k += 2) begin
      s += {16'h0, em[k], ((k + 1 < lim) ? em[k+1] : 8'h00)};
    end
    while ((s >> 16) != 0) s = (s & 32'hFFFF) + (s >> 16);
    r = ~s[15:0];
    if (is_b && u && r == 16'h0000) r = 16'hFFFF;
    em[ia]     = r[15:8];
    em[ia + 1] = r[7:0];
  endtask

  task automatic send_frame(input vec_t v, input int nbytes);
    for (int i = 0; i < nbytes; i++) begin
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1;
      in_data  = gen(i, v.seed);
      in_last  = (i == nbytes - 1);
      if (i == 0) begin
        a_en = v.a_en; a_s = v.a_s; a_e = v.a_e; a_i = v.a_i;
        b_en = v.b_en; b_s = v.b_s; b_e = v.b_e; b_i = v.b_i;
        udp  = v.udp;
      end else begin
        // R2: later control values must be ignored
        a_en = ~v.a_en; a_s = 6'd33; a_e = 6'd7; a_i = 6'd1;
        b_en = ~v.b_en; b_s = 6'd2;  b_e = 6'd9; b_i = 6'd5;
        udp  = ~v.udp;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
    check("R1 in_ready low after last byte", int'(in_ready), 0);
  endtask

  task automatic collect();
    int guard;
    ngot  = 0;
    guard = 0;
    while (guard < 3000) begin
      @(negedge clk);
      guard++;
      if (out_valid) begin
        got[ngot] = out_data;
        ngot++;
        if (out_last) break;
      end
    end
  endtask

  task automatic compare(input string tag, input int exp_len);
    int first_bad;
    check({tag, " length"}, ngot, exp_len);
    first_bad = -1;
    for (int i = 0; i < exp_len && i < ngot; i++) begin
      if (got[i] !== em[i] && first_bad < 0) first_bad = i;
    end
    total = total + 1;
    if (first_bad >= 0) begin
      bad = bad + 1;
      $display("FAIL %s byte %0d: actual=%0h expected=%0h",
               tag, first_bad, got[first_bad], em[first_bad]);
    end
  endtask

  initial begin
    in_valid = 1'b0; in_last = 1'b0; in_data = '0;
    a_en = 0; a_s = '0; a_e = '0; a_i = '0;
    b_en = 0; b_s = '0; b_e = '0; b_i = '0; udp = 0;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 reset state
    check("R10 out_valid after reset", int'(out_valid), 0);
    check("R10 out_last after reset", int'(out_last), 0);
    check("R10 in_ready after reset", int'(in_ready), 1);

    // table walk: R1 R2 R3 R4 R5 R6 R7 R8 R9
    for (int n = 0; n < 10; n++) begin
      vec_t v;
      v = VT[n];
      for (int i = 0; i < 128; i++) em[i] = (i < int'(v.len)) ? gen(i, v.seed) : 8'h00;
      if (v.b_en) model_ctx(int'(v.b_s), int'(v.b_e), int'(v.b_i), 1'b1, v.udp, int'(v.len));
      if (v.a_en) model_ctx(int'(v.a_s), int'(v.a_e), int'(v.a_i), 1'b0, v.udp, int'(v.len));
      send_frame(v, int'(v.len));
      collect();
      compare($sformatf("R3 R4 R5 R6 R7 R8 R9 vector %0d", n), int'(v.len));
    end

    // R9 directed: all-0xFF frame, inner result field value
    begin
      vec_t v;
      v = VT[4];
      for (int i = 0; i < 128; i++) em[i] = (i < 16) ? 8'hFF : 8'h00;
      model_ctx(0, 0, 2, 1'b1, 1'b1, 16);
      send_frame(v, 16);
      collect();
      check("R9 zero result sent as FFFF", {24'h0, got[2], got[3]}, 32'hFFFF);
    end

    // R7 both off: frame unchanged
    begin
      vec_t v;
      v = VT[8];
      for (int i = 0; i < 128; i++) em[i] = gen(i, v.seed);
      send_frame(v, int'(v.len));
      collect();
      compare("R7 both contexts off", int'(v.len));
    end

    // R11 overflow: bytes beyond capacity dropped
    begin
      vec_t v;
      v = VT[8];
      for (int i = 0; i < 128; i++) em[i] = gen(i, v.seed);
      send_frame(v, MAXF + 3);
      collect();
      compare("R11 oversize frame", MAXF);
    end

    repeat (3) @(negedge clk);
    check("R10 idle ready after traffic", int'(in_ready), 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule